// File: doc/BRIEF.md
# Sandcastle Code and Vertical Blanking Generator

This block turns line-rate and field-rate timing events of a TV deflection controller into a two-bit sandcastle control code. The code has three active levels. The highest marks the window for colour-burst gating and black-level clamping. The middle level marks horizontal blanking. The lowest level marks vertical blanking. A fourth code means that no level is active. Downstream logic turns this code into the analog multi-level pulse. The analog drive and the oscillators are not part of this block.

The block counts horizontal pulses between vertical sync edges and from that count decides whether the field rate is 50 Hz or 60 Hz. The decision is also driven out as its own port. The length of the vertical blanking interval follows the decision: 21 lines at 50 Hz and 17 lines at 60 Hz. The burst window is a parameterised number of clock cycles. It starts right after the trailing edge of each horizontal pulse. The horizontal blanking level follows the flyback input.

Top module: `sandcastle_gen`

## Requirements
- R1: `sc_level_o` uses these codes: 2'b11 for burst/clamp, 2'b10 for horizontal blanking, 2'b01 for vertical blanking and 2'b00 for none. When several levels are active at once, the code of the highest one is driven, in the order burst, then horizontal blanking, then vertical blanking.
- R2: A falling edge of `hpulse_i` is seen on the clock edge where `hpulse_i` samples low after it sampled high on the previous edge. After that edge, `sc_level_o` reads 2'b11 for exactly BURST_TICKS (default 4) cycles. Another falling edge restarts the window.
- R3: When no burst window is active, `sc_level_o` reads 2'b10 in each cycle that follows a clock edge where `flyback_i` sampled high. This is one cycle of latency.
- R4: A rising edge of `vsync_i` raises `vblank_o` one cycle later. It also restarts the line count of any blanking interval that is already running.
- R5: At 50 Hz (`rate60_o` = 0), `vblank_o` falls on the 21st rising edge of `hpulse_i` after the vsync edge that started the interval. It stays high until then.
- R6: At 60 Hz (`rate60_o` = 1), `vblank_o` falls on the 17th such rising edge.
- R7: A field holds the rising edges of `hpulse_i` counted between two rising edges of `vsync_i`. A field is classified as 60 Hz when it holds fewer than LINES_THR (default 288) of these edges. Otherwise it is classified as 50 Hz.
- R8: `rate60_o` changes only one cycle after a vsync rising edge. It changes only when the field just closed and the field before it were both classified the same way, and that class differs from the present output. A single field of the other class leaves `rate60_o` unchanged. The blanking interval started by the same vsync edge already uses the new length.
- R9: After reset, `sc_level_o` is 2'b00, `vblank_o` is 0 and `rate60_o` is 0. The stored previous classification is 50 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpulse_i | input | 1 | Horizontal-rate pulse, sampled on the clock |
| flyback_i | input | 1 | Horizontal flyback input |
| vsync_i | input | 1 | Vertical sync / retrace flag |
| sc_level_o | output | 2 | Encoded sandcastle level |
| vblank_o | output | 1 | Vertical blanking interval |
| rate60_o | output | 1 | Field-rate decision, 1 = 60 Hz |

## Verification
Every result is registered exactly once after the input edge that causes it. The burst code, the flyback level, the start and end of blanking and the rate decision therefore all show up in the cycle after the clock edge that sampled the stimulus. The bench drives inputs on the falling clock edge. It compares all outputs 2 ns after each rising edge against a bench model that applies the same one-edge rule. The bench also makes targeted checks in fixed cycles of each line: the rate right after the vsync edge, and the blanking level in the last cycle of line N-1 and of line N, where N is 21 or 17.

// File: rtl/sc_pkg.sv
package sc_pkg;

   typedef enum logic [1:0] {
      SC_NONE   = 2'b00,
      SC_VBLANK = 2'b01,
      SC_HBLANK = 2'b10,
      SC_BURST  = 2'b11
   } sc_code_e;

endpackage

// File: rtl/sc_burst_win.sv
module sc_burst_win #(
   parameter int BURST_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hp_fall,
   output logic burst_on
);
   localparam int BW = $clog2(BURST_TICKS + 1);
   localparam logic [BW-1:0] LOAD_V = BW'(BURST_TICKS);

   logic [BW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               left_q <= '0;
      else if (hp_fall)         left_q <= LOAD_V;
      else if (left_q != '0)    left_q <= left_q - 1'b1;
   end

   assign burst_on = (left_q != '0);

   // R2: a trailing edge always opens the window on the next cycle
   assert_burst_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hp_fall |=> burst_on);

endmodule

// File: rtl/sc_field_rate.sv
module sc_field_rate #(
   parameter int LINES_THR = 288
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hp_rise,
   input  logic vs_rise,
   output logic rate60
);
   localparam int LW = $clog2(LINES_THR) + 2;
   localparam logic [LW-1:0] THR_V = LW'(LINES_THR);

   logic [LW-1:0] lines_q;
   logic          prev_cls_q;
   logic          rate_q;
   logic          cls;

   assign cls = (lines_q < THR_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q    <= '0;
         prev_cls_q <= 1'b0;
         rate_q     <= 1'b0;
      end else if (vs_rise) begin
         lines_q    <= '0;
         prev_cls_q <= cls;
         if (cls == prev_cls_q) rate_q <= cls;
      end else if (hp_rise && (lines_q != '1)) begin
         lines_q <= lines_q + 1'b1;
      end
   end

   assign rate60 = rate_q;

   // R8: the decision moves only on a vsync edge
   assert_rate_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !vs_rise |=> $stable(rate_q));

endmodule

// File: rtl/sc_vblank_cnt.sv
module sc_vblank_cnt #(
   parameter int VB_LINES_50 = 21,
   parameter int VB_LINES_60 = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hp_rise,
   input  logic vs_rise,
   input  logic rate60,
   output logic vblank
);
   localparam int VMAX = (VB_LINES_50 > VB_LINES_60) ? VB_LINES_50 : VB_LINES_60;
   localparam int VW   = $clog2(VMAX + 1);
   localparam logic [VW-1:0] LAST50 = VW'(VB_LINES_50 - 1);
   localparam logic [VW-1:0] LAST60 = VW'(VB_LINES_60 - 1);

   logic [VW-1:0] cnt_q;
   logic          vb_q;
   logic [VW-1:0] last;

   assign last = rate60 ? LAST60 : LAST50;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         vb_q  <= 1'b0;
      end else if (vs_rise) begin
         cnt_q <= '0;
         vb_q  <= 1'b1;
      end else if (vb_q && hp_rise) begin
         if (cnt_q == last) vb_q <= 1'b0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign vblank = vb_q;

   // R4: a vsync edge always opens blanking
   assert_vb_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise |=> vb_q);
   // R5: blanking ends only on a line pulse
   assert_vb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vb_q && !vs_rise && !hp_rise) |=> vb_q);
   // R6: the line count never passes the selected length
   assert_vb_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vb_q |-> (cnt_q <= last));

endmodule

// File: rtl/sandcastle_gen.sv
module sandcastle_gen #(
   parameter int BURST_TICKS  = 4,
   parameter int LINES_THR    = 288,
   parameter int VB_LINES_50  = 21,
   parameter int VB_LINES_60  = 17,
   parameter bit SYNC_FLYBACK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hpulse_i,
   input  logic       flyback_i,
   input  logic       vsync_i,
   output logic [1:0] sc_level_o,
   output logic       vblank_o,
   output logic       rate60_o
);
   import sc_pkg::*;

   if (BURST_TICKS < 1) begin : g_bad_burst
      $error("BURST_TICKS must be at least 1");
   end
   if (LINES_THR < 2) begin : g_bad_thr
      $error("LINES_THR must be at least 2");
   end
   if (VB_LINES_50 < 1 || VB_LINES_60 < 1) begin : g_bad_vb
      $error("blanking lengths must be at least 1");
   end

   logic hp_q, vs_q;
   logic hp_rise, hp_fall, vs_rise;
   logic burst_on, hb_on, vb_on, rate60;
   sc_code_e code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hp_q <= 1'b0;
         vs_q <= 1'b0;
      end else begin
         hp_q <= hpulse_i;
         vs_q <= vsync_i;
      end
   end

   assign hp_rise = hpulse_i & ~hp_q;
   assign hp_fall = ~hpulse_i & hp_q;
   assign vs_rise = vsync_i & ~vs_q;

   if (SYNC_FLYBACK) begin : g_fly_reg
      logic fb_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) fb_q <= 1'b0;
         else        fb_q <= flyback_i;
      end
      assign hb_on = fb_q;
   end else begin : g_fly_comb
      assign hb_on = flyback_i;
   end

   sc_burst_win #(.BURST_TICKS(BURST_TICKS)) u_burst (
      .clk(clk), .rst_n(rst_n), .hp_fall(hp_fall), .burst_on(burst_on));

   sc_field_rate #(.LINES_THR(LINES_THR)) u_rate (
      .clk(clk), .rst_n(rst_n), .hp_rise(hp_rise), .vs_rise(vs_rise),
      .rate60(rate60));

   sc_vblank_cnt #(.VB_LINES_50(VB_LINES_50), .VB_LINES_60(VB_LINES_60)) u_vb (
      .clk(clk), .rst_n(rst_n), .hp_rise(hp_rise), .vs_rise(vs_rise),
      .rate60(rate60), .vblank(vb_on));

   always_comb begin
      if (burst_on)   code = SC_BURST;
      else if (hb_on) code = SC_HBLANK;
      else if (vb_on) code = SC_VBLANK;
      else            code = SC_NONE;
   end

   assign sc_level_o = code;
   assign vblank_o   = vb_on;
   assign rate60_o   = rate60;

   // R1: while the burst window is open no lower code is driven
   assert_burst_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hp_fall |=> (sc_level_o == 2'b11));

endmodule

// File: tb/sandcastle_gen_tb_top.sv
module sandcastle_gen_tb_top;
   localparam int BT  = 4;
   localparam int THR = 288;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic hp = 1'b0, fb = 1'b0, vs = 1'b0;
   logic [1:0] level;
   logic vblank, rate60;

   sandcastle_gen dut_i (
      .clk(clk), .rst_n(rst_n), .hpulse_i(hp), .flyback_i(fb), .vsync_i(vs),
      .sc_level_o(level), .vblank_o(vblank), .rate60_o(rate60));

   int total = 0, bad = 0;
   bit done = 0, cmp_en = 0;

   // bench model of the requirements
   int m_bl, m_vl, m_lines;
   bit m_vb, m_fly, m_rate, m_prev, m_hpd, m_vsd, hr, hf, vr, cls;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_bl = 0; m_vl = 0; m_lines = 0;
         m_vb = 0; m_fly = 0; m_rate = 0; m_prev = 0; m_hpd = 0; m_vsd = 0;
      end else begin
         hr = hp && !m_hpd;
         hf = !hp && m_hpd;
         vr = vs && !m_vsd;
         if (hf) m_bl = BT; else if (m_bl > 0) m_bl = m_bl - 1;
         m_fly = fb;
         if (vr) begin
            cls = (m_lines < THR);
            if (cls == m_prev && cls != m_rate) m_rate = cls;
            m_prev = cls; m_lines = 0; m_vb = 1; m_vl = 0;
         end else begin
            if (hr) m_lines = m_lines + 1;
            if (m_vb && hr) begin
               m_vl = m_vl + 1;
               if (m_vl == (m_rate ? 17 : 21)) m_vb = 0;
            end
         end
         m_hpd = hp; m_vsd = vs;
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (cmp_en) begin
         int exp_lv;
         exp_lv = (m_bl != 0) ? 3 : m_fly ? 2 : m_vb ? 1 : 0;
         case (exp_lv)
            3: chk(level == 2'(exp_lv), "R2 burst level", level, exp_lv);
            2: chk(level == 2'(exp_lv), "R3 hblank level", level, exp_lv);
            1: chk(level == 2'(exp_lv), "R4 vblank level", level, exp_lv);
            default: chk(level == 2'(exp_lv), "R1 none level", level, exp_lv);
         endcase
         chk(vblank == m_vb, "R5 vblank", vblank, m_vb);
         chk(rate60 == m_rate, "R7 rate", rate60, m_rate);
      end
   end

   task automatic run_line(int ln, bit exp_rate, bit tail);
      int vlen;
      vlen = exp_rate ? 17 : 21;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         hp = (c < 2);
         fb = (ln % 4 != 3) && (c >= 1 + ln % 3) && (c <= 3 + ln % 3);
         vs = (ln <= 2) && (ln > 0 || c >= 5);
         if (c == 9) begin
            @(posedge clk); #2;
            if (ln == 0)
               chk(rate60 == exp_rate, "R8 rate after vsync", rate60, exp_rate);
            if (!tail && ln == vlen - 1)
               chk(vblank == 1'b1, exp_rate ? "R6 blank held" : "R5 blank held", vblank, 1);
            if (!tail && ln == vlen)
               chk(vblank == 1'b0, exp_rate ? "R6 blank end" : "R5 blank end", vblank, 0);
         end
      end
   endtask

   int flines [11] = '{300, 300, 300, 262, 300, 262, 262, 262, 300, 300, 300};
   bit frate  [11] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0};

   initial begin
      repeat (5) @(negedge clk);
      chk(level == 2'b00, "R9 reset level", level, 0);
      chk(vblank == 1'b0, "R9 reset vblank", vblank, 0);
      chk(rate60 == 1'b0, "R9 reset rate", rate60, 0);
      rst_n = 1'b1;
      cmp_en = 1;
      for (int f = 0; f < 11; f++)
         for (int ln = 0; ln < flines[f]; ln++)
            run_line(ln, frate[f], 1'b0);
      // closing vsync classifies the last field
      for (int ln = 0; ln < 3; ln++) run_line(ln, 1'b0, 1'b1);
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule